// File: doc/BRIEF.md
# Backlight PWM Generator

This block drives one panel backlight pin with a pulse-width modulated waveform. Software programs it through a plain register write port with two 32-bit registers. The control register holds the run enable, the output polarity, a stored override flag and the tick-size select. The level register holds the period count in its upper half and the duty count in its lower half. A prescaler divides the core clock into ticks of 16 or 128 clocks. A position counter walks through the period one tick at a time. The pin is active while the position is below the duty count.

The expected use is as follows. Program the polarity and tick size while the generator is stopped, load the level register, then set enable in a later write. Brightness can change while the generator runs. New level values are held in the level register and reach the comparator only when the current period ends, so no partial pulse appears. Both registers read back through a combinational read port.

The register port has no back-pressure. Every cycle with `wr_en` high is a completed write. A read returns data in the same cycle `rd_sel` is applied.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, `pwm_out` is 0 and both registers read as zero.
- R2: Register select 0 is the control register and select 1 is the level register, for both writes and reads. In the control register, bit 31 is enable, bit 30 is override, bit 29 is polarity (1 = active-low) and bit 0 is the tick select. All other bits read as 0.
- R3: The level register holds the period count in bits 31:16 and the duty count in bits 15:0, and reads back what was written.
- R4: A tick lasts 16 clocks when the tick select is 0 and 128 clocks when it is 1. While enabled, the output repeats every period×tick clocks and is active for duty×tick clocks at the start of each period.
- R5: A control write made while the stored enable is 1 leaves polarity and tick select unchanged.
- R6: From the cycle after a control write that clears enable, `pwm_out` sits at its inactive level. That level equals the polarity bit.
- R7: The override bit is stored and read back, and it has no effect on `pwm_out`.
- R8: While disabled, the tick and position counters stay at zero. Each enable therefore starts a fresh period, active from the first clock after the enabling write when the duty count is nonzero.
- R9: A level write during a running period changes nothing until that period ends. The new values govern the next period.
- R10: A duty count of 0 keeps the output inactive. A nonzero duty count that is at least the period count keeps the output active; this includes a period count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the reference for ticks |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_sel | input | 1 | Write target: 0 control, 1 level |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 level |
| rd_data | output | 32 | Read data of the selected register |
| pwm_out | output | 1 | Backlight PWM pin |

## Verification
A stuck or misaligned tick counter shows up at the pin within the first period after enable. The active time per period then differs from duty×tick, so a two-period count of active cycles exposes it. If compare values are not shadowed, or are reloaded at the wrong moment, the mid-period duty change lengthens the current pulse at once instead of one period later. A polarity or tick field that does not lock while running appears at the next control read, and in the pin's idle level right after disable.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned CNT_W    = REG_W / 2;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned OVR_BIT  = 30;
  localparam int unsigned POL_BIT  = 29;
  localparam int unsigned GRAN_BIT = 0;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_LEVEL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             en,
  output logic             ovr,
  output logic             pol,
  output logic             gran,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] duty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      ovr    <= 1'b0;
      pol    <= 1'b0;
      gran   <= 1'b0;
      period <= '0;
      duty   <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL) begin
        en  <= wr_data[EN_BIT];
        ovr <= wr_data[OVR_BIT];
        // output shape fields only accepted while stopped
        if (!en) begin
          pol  <= wr_data[POL_BIT];
          gran <= wr_data[GRAN_BIT];
        end
      end else begin
        period <= wr_data[CNT_W +: CNT_W];
        duty   <= wr_data[0 +: CNT_W];
      end
    end
  end

  logic [REG_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word           = '0;
    ctrl_word[EN_BIT]   = en;
    ctrl_word[OVR_BIT]  = ovr;
    ctrl_word[POL_BIT]  = pol;
    ctrl_word[GRAN_BIT] = gran;
  end

  assign rd_data = (rd_sel == SEL_CTRL) ? ctrl_word : {period, duty};
endmodule

// File: rtl/bl_pwm_tick.sv
module bl_pwm_tick #(
  parameter int unsigned INC_LO = 16,
  parameter int unsigned INC_HI = 128,
  localparam int unsigned PRE_W = $clog2(INC_HI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             gran,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt
);
  logic [PRE_W-1:0] last_cnt;
  assign last_cnt = gran ? PRE_W'(INC_HI - 1) : PRE_W'(INC_LO - 1);
  assign tick     = run && (pre_cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (!run)   pre_cnt <= '0;
    else if (tick)   pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_cmp.sv
module bl_pwm_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             active,
  output logic             wrap,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] duty_act
);
  logic [CNT_W-1:0] per_act;
  logic             at_end;

  assign at_end = (per_act <= CNT_W'(1)) || (pos == per_act - 1'b1);
  assign wrap   = tick && at_end;
  assign active = run && (duty_act != '0) && (pos < duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (!run) begin
      pos      <= '0;
      per_act  <= period;
      duty_act <= duty;
    end else if (tick) begin
      if (at_end) begin
        pos      <= '0;
        per_act  <= period;
        duty_act <= duty;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int unsigned INC_LO = 16,
  parameter int unsigned INC_HI = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int unsigned PRE_W = $clog2(INC_HI);

  logic             en, ovr, pol, gran, tick, active, wrap;
  logic [CNT_W-1:0] period, duty, pos, duty_act;
  logic [PRE_W-1:0] pre_cnt;

  bl_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .en(en), .ovr(ovr), .pol(pol), .gran(gran),
    .period(period), .duty(duty)
  );

  bl_pwm_tick #(.INC_LO(INC_LO), .INC_HI(INC_HI)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(en), .gran(gran),
    .tick(tick), .pre_cnt(pre_cnt)
  );

  bl_pwm_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .run(en), .tick(tick),
    .period(period), .duty(duty), .active(active), .wrap(wrap),
    .pos(pos), .duty_act(duty_act)
  );

  assign pwm_out = pol ^ active;
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int unsigned PRE_W = 7,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [31:0]      wr_data,
  input logic             en,
  input logic             ovr,
  input logic             pol,
  input logic             pwm_out,
  input logic             wrap,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-1:0] pos,
  input logic [CNT_W-1:0] duty_act
);
  a_r6_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wr_data[31]) |=> (pwm_out == pol));

  a_r5_pol_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && !wr_sel) |=> $stable(pol));

  a_r7_ovr_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (ovr == $past(wr_data[30])));

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (pre == '0 && pos == '0));

  a_r9_duty_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(duty_act) || !en));
endmodule

bind bl_pwm_top bl_pwm_chk #(.PRE_W(PRE_W), .CNT_W(bl_pwm_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .en(en), .ovr(ovr), .pol(pol), .pwm_out(pwm_out),
  .wrap(wrap), .pre(pre_cnt), .pos(pos), .duty_act(duty_act)
);

// File: tb/sim_bl_pwm_top.sv
`timescale 1ns/1ps
module sim_bl_pwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  bl_pwm_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // {gran, pol, ovr, period[7:0], duty[7:0], active clocks per period[15:0]}
  localparam logic [34:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 8'd4, 8'd1, 16'd16},
    {1'b0, 1'b1, 1'b0, 8'd5, 8'd3, 16'd48},
    {1'b0, 1'b0, 1'b1, 8'd3, 8'd2, 16'd32},
    {1'b0, 1'b0, 1'b0, 8'd4, 8'd0, 16'd0},
    {1'b0, 1'b1, 1'b0, 8'd3, 8'd9, 16'd48},
    {1'b1, 1'b0, 1'b0, 8'd2, 8'd1, 16'd128},
    {1'b1, 1'b1, 1'b1, 8'd3, 8'd2, 16'd256}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    rd_sel = sel;
    #0.5;
    d = rd_data;
  endtask

  initial begin
    logic [31:0] r;
    int act_a, act_b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwm_out", {31'b0, pwm_out}, 32'd0);
    rd(1'b0, r); chk("R1 ctrl", r, 32'd0);
    rd(1'b1, r); chk("R1 level", r, 32'd0);

    // R3 level readback
    wr(1'b1, 32'hABCD_1234);
    rd(1'b1, r); chk("R3 level readback", r, 32'hABCD_1234);

    // R2/R7 control readback with override and tick select
    wr(1'b0, 32'h6000_0001);
    rd(1'b0, r); chk("R2 R7 ctrl readback", r, 32'h6000_0001);

    // vector table: R4, R7, R8, R10, R6
    for (int i = 0; i < 7; i++) begin
      logic g, p, o;
      logic [7:0] per, dut;
      int inc, exp_a;
      {g, p, o, per, dut} = VEC[i][34:16];
      exp_a = int'(VEC[i][15:0]);
      inc = g ? 128 : 16;
      wr(1'b0, {2'b00, p, 28'd0, g});
      wr(1'b1, {8'd0, per, 8'd0, dut});
      wr(1'b0, {1'b1, o, p, 28'd0, g});
      chk("R8 first clock active", {31'b0, pwm_out ^ p}, {31'b0, exp_a != 0});
      act_a = 0;
      for (int k = 0; k < 2 * int'(per) * inc; k++) begin
        if ((pwm_out ^ p) == 1'b1) act_a++;
        @(negedge clk);
      end
      chk("R4 R10 active clocks", act_a, 2 * exp_a);
      wr(1'b0, {2'b00, p, 28'd0, g});
      chk("R6 idle level", {31'b0, pwm_out}, {31'b0, p});
    end

    // R8 disabled with nonzero duty stays idle
    wr(1'b0, 32'h0000_0000);
    wr(1'b1, {16'd4, 16'd2});
    act_a = 0;
    for (int k = 0; k < 100; k++) begin
      if (pwm_out) act_a++;
      @(negedge clk);
    end
    chk("R8 idle while disabled", act_a, 0);

    // R5 polarity and tick select locked while running
    wr(1'b1, {16'd4, 16'd0});
    wr(1'b0, 32'h8000_0000);
    wr(1'b0, 32'hA000_0001);
    rd(1'b0, r); chk("R5 ctrl locked", r, 32'h8000_0000);
    chk("R5 output unchanged", {31'b0, pwm_out}, 32'd0);
    wr(1'b0, 32'h0000_0000);

    // R10 period 0 with nonzero duty: fully active
    wr(1'b1, {16'd0, 16'd5});
    wr(1'b0, 32'h8000_0000);
    act_a = 0;
    for (int k = 0; k < 64; k++) begin
      if (pwm_out) act_a++;
      @(negedge clk);
    end
    chk("R10 period zero full", act_a, 64);
    wr(1'b0, 32'h0000_0000);

    // R9 duty change mid-period waits for the boundary
    wr(1'b1, {16'd8, 16'd2});
    wr(1'b0, 32'h8000_0000);
    act_a = 0; act_b = 0;
    for (int k = 0; k < 256; k++) begin
      if (k == 40) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = {16'd8, 16'd6}; end
      if (k == 41) wr_en = 1'b0;
      if (pwm_out) begin
        if (k < 128) act_a++; else act_b++;
      end
      @(negedge clk);
    end
    chk("R9 current period keeps old duty", act_a, 32);
    chk("R9 next period uses new duty", act_b, 96);
    wr(1'b0, 32'h0000_0000);

    summary();
  end
endmodule